// File: doc/BRIEF.md
# Reversible-Gate Decimal Digit Adder/Subtractor

This block adds or subtracts one pair of decimal digits. Each digit is a 4-bit binary value in the range 0 to 9. The block is purely combinational. Every operation in it is built from reversible gate primitives: NOT, controlled-NOT (Feynman), Toffoli, Fredkin and Peres. Every gate has as many outputs as inputs. Extra inputs are tied to constants, and each output that carries no result is routed to a garbage bus. The whole network is therefore a one-to-one map from its inputs and constants to its result and garbage lines.

The datapath runs through these stages in order:
- The second operand is copied with controlled-NOT fanouts.
- A gate network with no garbage forms the nines' complement of the copy.
- A chain of Fredkin gates picks either the plain operand or its complement, according to `sub`.
- A ripple binary adder adds the two operands and the carry-in.
- A detector flags any binary sum above nine.
- A second ripple adder adds six when the flag is set.

For subtraction, the nines' complement of `b` is added, and `cin` acts as an active-low borrow. A lone digit therefore drives `cin` high to compute a − b. To build a multi-digit adder, chain instances by connecting each `cout` to the next digit's `cin`. The parameter `FA_STYLE` picks the full-adder gate network: two Peres gates, or two Toffoli and two Feynman gates. Both networks produce the same garbage lines.

Top module: `rbcd_digit_addsub`

## Requirements
- R1: With `sub`=0 and digits 0..9, the value `cout`*10 + `digit` equals a + b + cin, where `cout` is 1 exactly when that sum exceeds 9. With all inputs at zero, both outputs read zero.
- R2: With `sub`=1 and `cin`=1 (no borrow pending), the outputs are as follows. For a ≥ b, `digit` = a − b and `cout` = 1. For a < b, `digit` = a − b + 10 and `cout` = 0.
- R3: With `sub`=1 and `cin`=0 (borrow pending), the outputs are as follows. For a > b, `digit` = a − b − 1 and `cout` = 1. Otherwise, `digit` = a − b + 9 and `cout` = 0.
- R4: The nines' complement stage maps each digit d in 0..9 to 9 − d. It is seen at the ports as `digit` = 9 − b, `cout` = 0 when a = 0, `cin` = 0 and `sub` = 1.
- R5: Binary sums from 10 to 19 are corrected by adding six and keeping the low 4 bits, and `cout` is the over-nine flag. A binary sum of exactly 9 is left uncorrected. In the sum of 16 and above, the binary carry alone raises the flag.
- R6: `garbage` is 25 bits wide. Across all 400 valid input combinations, the 30-bit tuple {`digit`, `cout`, `garbage`} is distinct for every input, so the network is injective.
- R7: Each gate primitive (NOT, Feynman, Toffoli, Fredkin, Peres) is a bijection on its input space.
- R8: Both full-adder variants (`FA_STYLE` 0 and 1) give identical `digit`, `cout` and `garbage` for every valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | First decimal digit (0..9) |
| b | input | 4 | Second decimal digit (0..9) |
| cin | input | 1 | Carry-in for add; active-low borrow-in for subtract |
| sub | input | 1 | 0 = add, 1 = subtract (adds nines' complement of b) |
| digit | output | 4 | Decimal result digit |
| cout | output | 1 | Decimal carry-out; for subtract, 1 means no borrow |
| garbage | output | 25 | Garbage lines of the reversible network |

## Verification
The hardest condition to reach is a collision in the garbage tuple. Such a collision would show that two inputs merge inside the network. It can only be seen by comparing the results of all input combinations against each other, not from any single cycle. The stimulus therefore sweeps every digit pair under all four settings of `sub` and `cin` and records each full output tuple. It then checks every pair of records for a duplicate. The same sweep drives a second instance built with the other full-adder variant, and the bench compares the two instances cycle by cycle. Corner sums of 9, 10, 16 and 19 are also driven on their own, to separate the uncorrected case from the detector's carry path.

// File: rtl/rbcd_pkg.sv
package rbcd_pkg;
   localparam int DIGIT_W   = 4;
   localparam int FA_PERES  = 0;
   localparam int FA_TOFFOL = 1;

   // Reversible primitives (R7). Bit packing: input [2]=A,[1]=B,[0]=C,
   // output [2]=P,[1]=Q,[0]=R. Two-line gates: [1]=A/P, [0]=B/Q.
   function automatic logic rg_not(input logic x);
      return ~x;
   endfunction

   function automatic logic [1:0] rg_feynman(input logic [1:0] i);
      return {i[1], i[1] ^ i[0]};
   endfunction

   function automatic logic [2:0] rg_toffoli(input logic [2:0] i);
      return {i[2], i[1], (i[2] & i[1]) ^ i[0]};
   endfunction

   function automatic logic [2:0] rg_fredkin(input logic [2:0] i);
      return {i[2], i[2] ? i[0] : i[1], i[2] ? i[1] : i[0]};
   endfunction

   function automatic logic [2:0] rg_peres(input logic [2:0] i);
      return {i[2], i[2] ^ i[1], (i[2] & i[1]) ^ i[0]};
   endfunction
endpackage

// File: rtl/rbcd_full_adder.sv
module rbcd_full_adder
   import rbcd_pkg::*;
#(
   parameter int FA_STYLE = FA_PERES
) (
   input  logic       a,
   input  logic       b,
   input  logic       cin,
   output logic       sum,
   output logic       cout,
   output logic [1:0] garb
);
   // Both variants leave the same garbage lines {a, a^b} (R8).
   generate
      if (FA_STYLE == FA_PERES) begin : g_peres
         logic [2:0] p1, p2;
         always_comb begin
            p1   = rg_peres({a, b, 1'b0});
            p2   = rg_peres({p1[1], cin, p1[0]});
            sum  = p2[1];
            cout = p2[0];
            garb = {p1[2], p2[2]};
         end
      end else if (FA_STYLE == FA_TOFFOL) begin : g_toffoli
         logic [2:0] t1, t2;
         logic [1:0] f1, f2;
         always_comb begin
            t1   = rg_toffoli({a, b, 1'b0});
            f1   = rg_feynman({t1[2], t1[1]});
            t2   = rg_toffoli({f1[0], cin, t1[0]});
            f2   = rg_feynman({t2[2], t2[1]});
            sum  = f2[0];
            cout = t2[0];
            garb = {f1[1], f2[1]};
         end
      end else begin : g_bad_style
         $error("rbcd_full_adder: FA_STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      p_fa_add_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {1'b0, cin}))
         else $error("full adder arithmetic mismatch");
   end
endmodule

// File: rtl/rbcd_ripple_adder.sv
module rbcd_ripple_adder
   import rbcd_pkg::*;
#(
   parameter int WIDTH    = DIGIT_W,
   parameter int FA_STYLE = FA_PERES
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic               cin,
   output logic [WIDTH-1:0]   sum,
   output logic               cout,
   output logic [2*WIDTH-1:0] garb
);
   localparam int GARB_W = 2 * WIDTH;

   logic [WIDTH:0] carry;
   assign carry[0] = cin;
   assign cout     = carry[WIDTH];

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rbcd_ripple_adder: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         rbcd_full_adder #(.FA_STYLE(FA_STYLE)) u_fa (
            .a    (a[i]),
            .b    (b[i]),
            .cin  (carry[i]),
            .sum  (sum[i]),
            .cout (carry[i+1]),
            .garb (garb[2*i+1:2*i])
         );
      end
   endgenerate

   always_comb begin
      p_ripple_add_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
         else $error("ripple adder mismatch, garbage width %0d", GARB_W);
   end
endmodule

// File: rtl/rbcd_nines_comp.sv
module rbcd_nines_comp
   import rbcd_pkg::*;
(
   input  logic [DIGIT_W-1:0] d,
   output logic [DIGIT_W-1:0] q
);
   // Garbage-free 4-line network: NOT, Toffoli, two CNOTs, NOT.
   logic [2:0] t;
   logic [1:0] f, g;
   always_comb begin
      t    = rg_toffoli({d[2], d[1], d[3]});
      f    = rg_feynman({t[1], t[2]});
      g    = rg_feynman({f[0], t[0]});
      q[0] = rg_not(d[0]);
      q[1] = f[1];
      q[2] = g[1];
      q[3] = rg_not(g[0]);
   end

   always_comb begin
      if (d <= 4'd9) begin
         p_ninecomp_map_r4: assert (q == 4'd9 - d)
            else $error("nines complement of %0d gave %0d", d, q);
      end
   end
endmodule

// File: rtl/rbcd_operand_mux.sv
module rbcd_operand_mux
   import rbcd_pkg::*;
#(
   parameter int WIDTH = DIGIT_W
) (
   input  logic             sel,
   input  logic [WIDTH-1:0] plain,
   input  logic [WIDTH-1:0] comp,
   output logic [WIDTH-1:0] op,
   output logic [WIDTH-1:0] garb,
   output logic             sel_out
);
   logic [WIDTH:0] ctl;
   assign ctl[0]  = sel;
   assign sel_out = ctl[WIDTH];

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rbcd_operand_mux: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         always_comb {ctl[i+1], op[i], garb[i]} = rg_fredkin({ctl[i], plain[i], comp[i]});
      end
   endgenerate

   always_comb begin
      p_mux_select_r2: assert (sel ? (op == comp && garb == plain)
                                   : (op == plain && garb == comp))
         else $error("operand mux routing error");
   end
endmodule

// File: rtl/rbcd_detector.sv
module rbcd_detector
   import rbcd_pkg::*;
(
   input  logic       s1,
   input  logic       s2,
   input  logic       s3,
   input  logic       c4,
   output logic       flag,
   output logic       s1_out,
   output logic [2:0] garb
);
   // Two Fredkin gates form s3&(s1|s2) from one zero constant; a CNOT merges
   // the binary carry, which never coincides with s3 for valid digit sums.
   logic [2:0] g1, g2;
   logic [1:0] g3;
   always_comb begin
      g1     = rg_fredkin({s3, 1'b0, s2});
      g2     = rg_fredkin({s1, g1[1], g1[2]});
      g3     = rg_feynman({c4, g2[1]});
      flag   = g3[0];
      s1_out = g2[2];
      garb   = {g1[0], g2[0], g3[1]};
   end

   always_comb begin
      if (!(c4 && s3)) begin
         p_detect_flag_r5: assert (flag == (((s1 | s2) & s3) | c4))
            else $error("over-nine flag mismatch");
      end
   end
endmodule

// File: rtl/rbcd_digit_addsub.sv
module rbcd_digit_addsub
   import rbcd_pkg::*;
#(
   parameter int FA_STYLE = FA_PERES
) (
   input  logic [3:0]  a,
   input  logic [3:0]  b,
   input  logic        cin,
   input  logic        sub,
   output logic [3:0]  digit,
   output logic        cout,
   output logic [24:0] garbage
);
   localparam int MUX_G  = DIGIT_W + 1;
   localparam int ADD_G  = 2 * DIGIT_W;
   localparam int DET_G  = 3;
   localparam int CORR_G = 2 * DIGIT_W + 1;
   localparam int GARB_W = MUX_G + ADD_G + DET_G + CORR_G;

   generate
      if (GARB_W != 25) begin : g_bad_garb
         $error("rbcd_digit_addsub: garbage width mismatch (R6)");
      end
      if (FA_STYLE != FA_PERES && FA_STYLE != FA_TOFFOL) begin : g_bad_style
         $error("rbcd_digit_addsub: unknown FA_STYLE");
      end
   endgenerate

   // operand copy by CNOT fanout with zero constants
   logic [DIGIT_W-1:0] b_keep, b_copy, b_nc, op, mux_g;
   logic               sel_out;
   generate
      for (genvar i = 0; i < DIGIT_W; i++) begin : g_fan
         always_comb {b_keep[i], b_copy[i]} = rg_feynman({b[i], 1'b0});
      end
   endgenerate

   rbcd_nines_comp u_nc (.d(b_copy), .q(b_nc));

   rbcd_operand_mux #(.WIDTH(DIGIT_W)) u_mux (
      .sel(sub), .plain(b_keep), .comp(b_nc),
      .op(op), .garb(mux_g), .sel_out(sel_out)
   );

   logic [DIGIT_W-1:0] bsum;
   logic               c4;
   logic [ADD_G-1:0]   add_g;
   rbcd_ripple_adder #(.WIDTH(DIGIT_W), .FA_STYLE(FA_STYLE)) u_add (
      .a(a), .b(op), .cin(cin), .sum(bsum), .cout(c4), .garb(add_g)
   );

   // copies of the sum bits the detector consumes
   logic s2_keep, s2_copy, s3_keep, s3_copy;
   always_comb begin
      {s2_keep, s2_copy} = rg_feynman({bsum[2], 1'b0});
      {s3_keep, s3_copy} = rg_feynman({bsum[3], 1'b0});
   end

   logic             flag, s1_pass;
   logic [DET_G-1:0] det_g;
   rbcd_detector u_det (
      .s1(bsum[1]), .s2(s2_copy), .s3(s3_copy), .c4(c4),
      .flag(flag), .s1_out(s1_pass), .garb(det_g)
   );

   // flag fans out to the two correction bits; its line becomes cout
   logic flag_a, flag_b, fix1, fix2;
   always_comb begin
      {flag_a, fix1} = rg_feynman({flag, 1'b0});
      {flag_b, fix2} = rg_feynman({flag_a, 1'b0});
   end
   assign cout = flag_b;

   logic             corr_c;
   logic [ADD_G-1:0] corr_g;
   rbcd_ripple_adder #(.WIDTH(DIGIT_W), .FA_STYLE(FA_STYLE)) u_corr (
      .a({s3_keep, s2_keep, s1_pass, bsum[0]}),
      .b({1'b0, fix2, fix1, 1'b0}),
      .cin(1'b0), .sum(digit), .cout(corr_c), .garb(corr_g)
   );

   assign garbage = {corr_g, corr_c, det_g, add_g, sel_out, mux_g};

   always_comb begin
      if (a <= 4'd9 && b <= 4'd9) begin
         p_digit_range_r5: assert (digit <= 4'd9)
            else $error("result digit %0d out of range", digit);
         if (!sub) begin
            p_add_value_r1: assert ((cout ? 10 : 0) + int'(digit) == int'(a) + int'(b) + int'(cin))
               else $error("add result mismatch");
         end else begin
            p_sub_value_r2: assert ((cout ? 10 : 0) + int'(digit) == int'(a) + 9 - int'(b) + int'(cin))
               else $error("subtract result mismatch");
         end
      end
   end
endmodule

// File: tb/rbcd_digit_addsub_test.sv
module rbcd_digit_addsub_test;
   import rbcd_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]  a = '0, b = '0;
   logic        cin = 1'b0, sub = 1'b0;
   logic [3:0]  digit, digit_alt;
   logic        cout, cout_alt;
   logic [24:0] garbage, garbage_alt;

   rbcd_digit_addsub #(.FA_STYLE(FA_PERES)) uut (
      .a(a), .b(b), .cin(cin), .sub(sub),
      .digit(digit), .cout(cout), .garbage(garbage)
   );
   rbcd_digit_addsub #(.FA_STYLE(FA_TOFFOL)) uut_alt (
      .a(a), .b(b), .cin(cin), .sub(sub),
      .digit(digit_alt), .cout(cout_alt), .garbage(garbage_alt)
   );

   int tests = 0, fails = 0;
   int    q_exp[$];
   int    q_idx[$];
   string q_req[$];
   logic [29:0] rec [400];
   bit          recd [400];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: applies one input set per cycle and queues the expectation
   task automatic drive(input int av, input int bv, input int cv, input int sv,
                        input string req, input int idx);
      int total;
      total = av + (sv != 0 ? 9 - bv : bv) + cv;
      @(posedge clk);
      a   = 4'(av);
      b   = 4'(bv);
      cin = cv[0];
      sub = sv[0];
      q_exp.push_back((total > 9 ? 16 : 0) + (total % 10));
      q_idx.push_back(idx);
      q_req.push_back(req);
   endtask

   // monitor: pops one expectation per cycle, mid-cycle
   always @(negedge clk) begin
      if (rst_n && q_exp.size() > 0) begin
         int e, idx;
         string r;
         e   = q_exp.pop_front();
         idx = q_idx.pop_front();
         r   = q_req.pop_front();
         check(int'(digit) == e % 16, r, "digit", int'(digit), e % 16);
         check(int'(cout) == e / 16, r, "cout", int'(cout), e / 16);
         check(digit_alt == digit && cout_alt == cout && garbage_alt == garbage,
               "R8", "variant outputs differ (garbage)", int'(garbage_alt), int'(garbage));
         if (idx >= 0) begin
            rec[idx]  = {digit, cout, garbage};
            recd[idx] = 1'b1;
         end
      end
   end

   task automatic gate_bijection_checks();
      int dup;
      bit seen [8];
      // NOT
      dup = 0;
      foreach (seen[k]) seen[k] = 1'b0;
      for (int i = 0; i < 2; i++) begin
         int o = int'(rg_not(i[0]));
         if (seen[o]) dup++;
         seen[o] = 1'b1;
      end
      check(dup == 0, "R7", "NOT duplicate outputs", dup, 0);
      // Feynman
      dup = 0;
      foreach (seen[k]) seen[k] = 1'b0;
      for (int i = 0; i < 4; i++) begin
         int o = int'(rg_feynman(i[1:0]));
         if (seen[o]) dup++;
         seen[o] = 1'b1;
      end
      check(dup == 0, "R7", "Feynman duplicate outputs", dup, 0);
      // three-line gates
      for (int g = 0; g < 3; g++) begin
         dup = 0;
         foreach (seen[k]) seen[k] = 1'b0;
         for (int i = 0; i < 8; i++) begin
            int o;
            o = (g == 0) ? int'(rg_toffoli(i[2:0])) :
                (g == 1) ? int'(rg_fredkin(i[2:0])) : int'(rg_peres(i[2:0]));
            if (seen[o]) dup++;
            seen[o] = 1'b1;
         end
         check(dup == 0, "R7", "3-line gate duplicate outputs", dup, g);
      end
      // Peres spot value: (1,1,0) -> P=1, Q=0, R=1
      check(rg_peres(3'b110) == 3'b101, "R7", "Peres 110", int'(rg_peres(3'b110)), 5);
   endtask

   initial begin
      foreach (recd[k]) recd[k] = 1'b0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all inputs zero
      drive(0, 0, 0, 0, "R1 reset", -1);
      // correction boundaries
      drive(9, 0, 0, 0, "R5 sum9", -1);
      drive(9, 1, 0, 0, "R5 sum10", -1);
      drive(8, 8, 0, 0, "R5 sum16 carry path", -1);
      drive(9, 9, 1, 0, "R5 sum19", -1);
      drive(7, 9, 0, 0, "R5 sum16b", -1);
      // subtract edges
      drive(5, 5, 1, 1, "R2 equal", -1);
      drive(0, 9, 1, 1, "R2 a<b", -1);
      drive(5, 5, 0, 1, "R3 equal borrow", -1);
      drive(9, 0, 0, 1, "R3 a>b borrow", -1);
      for (int bv = 0; bv < 10; bv++) drive(0, bv, 0, 1, "R4 complement", -1);
      // full sweep
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 2; c++)
            for (int av = 0; av < 10; av++)
               for (int bv = 0; bv < 10; bv++)
                  drive(av, bv, c, s, s == 0 ? "R1" : (c == 1 ? "R2" : "R3"),
                        (s * 2 + c) * 100 + av * 10 + bv);
      @(negedge clk);
      @(negedge clk);
      // injectivity over the whole valid domain
      begin
         int missing = 0, coll = 0;
         foreach (recd[k]) if (!recd[k]) missing++;
         check(missing == 0, "R6", "sweep records missing", missing, 0);
         for (int i = 0; i < 400; i++)
            for (int j = i + 1; j < 400; j++)
               if (rec[i] == rec[j]) coll++;
         check(coll == 0, "R6", "output tuple collisions", coll, 0);
         check($bits(garbage) == 25, "R6", "garbage width", $bits(garbage), 25);
      end
      gate_bijection_checks();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule